// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an 8-bit general-purpose I/O port that sits on a simple microcontroller register bus. Two registers control it: a direction register that decides, per pin, whether the port drives the pin, and an output-data latch that holds the value to drive. Each pin reaches the pad through a tri-state model with a separate drive value, drive enable and sampled input. The pad ring resolves these into the physical net.

An on-chip peripheral can claim any pin that the build marks as override-capable. It does so by raising that pin's peripheral output enable. Its own output value then drives the pin in place of the latch, whatever the direction bit holds. The live pin level always goes back to the peripheral inputs. A read of the data address always returns that live level, never the latch.

Reset clears the direction register, so every pin starts undriven. Reset leaves the latch alone. Software therefore loads the latch first and only then turns a pin to output, so the first value driven is a known one.

Top module: `gpio_port`

## Requirements
- R1: A pin whose direction bit is 1 and whose peripheral override is not active has its drive enable at 1 and drives the latch bit for that pin.
- R2: A pin whose direction bit is 0 and whose peripheral override is not active has its drive enable at 0, so the pad is left at high impedance.
- R3: A write to the data address (address 0) updates the latch in every mode. A pin in input mode keeps its drive enable at 0 after such a write.
- R4: A read at the data address (address 0) returns the live pin level in every combination of direction bit and peripheral override.
- R5: On a pin whose bit is set in PERIPH_MASK, an active peripheral output enable sets the drive enable to 1 and drives the peripheral's value, whatever the direction bit holds.
- R6: The peripheral input bus equals the live pin level at all times, including when the port itself drives the pin.
- R7: Asserting the active-low reset clears the direction register to all zeros, so every pin stops driving.
- R8: Reset does not change the latch. A value written before reset is driven once the pin is switched to output after reset.
- R9: A read at the direction address (address 1) returns the stored direction register.
- R10: A register write lands on the rising clock edge that samples the write strobe, and outputs change only after that edge. A write to an address other than 0 or 1 changes no register, and reads from such an address return zero.
- R11: On a pin whose bit is clear in PERIPH_MASK, the peripheral output enable is ignored. The pin follows R1 or R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset of the direction register |
| addr | input | ADDR_W | Register select: 0 selects the data latch or pin level, 1 selects direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data, combinational on addr |
| per_oe | input | WIDTH | Per-pin peripheral output enables |
| per_out | input | WIDTH | Per-pin peripheral output values |
| per_in | output | WIDTH | Live pin levels passed to peripherals |
| pin_in | input | WIDTH | Resolved pad level sampled from the pad |
| pin_out | output | WIDTH | Value presented to each pad driver |
| pin_oe | output | WIDTH | Pad driver enable, 1 drives |

## Verification
The main function is swept over a grid. Several direction patterns are crossed with several override patterns, and each grid point uses different latch, peripheral and external values. The bench is built with a mask that leaves the two top pins without override, so every pattern also shows whether masked pins ignore the enable. All-zero and all-one patterns separate the pure input and pure output cases from the peripheral cases. Alternating and nibble patterns show that each pin picks its own source, and would expose swapped or shared bits. Separate directed steps do three things. One samples the outputs just before and just after a write edge. One asserts reset between a latch write and the switch to output. One writes to and reads from an unmapped address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Source that feeds one pad driver
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_LATCH  = 2'd1,
      SRC_PERIPH = 2'd2
   } pad_src_e;

   function automatic pad_src_e pick_src(input logic dir_bit, input logic ovr_bit);
      if (ovr_bit)      return SRC_PERIPH;
      else if (dir_bit) return SRC_LATCH;
      else              return SRC_NONE;
   endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int WIDTH     = 8,
   parameter int ADDR_W    = 2,
   parameter int DATA_ADDR = 0,
   parameter int DIR_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  lat_q
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);

   logic wr_dat, wr_dir;

   always_comb begin
      wr_dat = wr_en && (addr == A_DATA);
      wr_dir = wr_en && (addr == A_DIR);
   end

   // Direction register: cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wr_data;
   end

   // Output latch: deliberately no reset, keeps its contents across reset
   always_ff @(posedge clk) begin
      if (wr_dat) lat_q <= wr_data;
   end

endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive
   import gpio_port_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter logic [WIDTH-1:0] PERIPH_MASK = '1
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] per_oe,
   input  logic [WIDTH-1:0] per_out,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (PERIPH_MASK[i]) begin : g_ovr
         pad_src_e src;
         always_comb begin
            src = pick_src(dir_q[i], per_oe[i]);
            unique case (src)
               SRC_PERIPH: begin pin_oe[i] = 1'b1; pin_out[i] = per_out[i]; end
               SRC_LATCH:  begin pin_oe[i] = 1'b1; pin_out[i] = lat_q[i];   end
               default:    begin pin_oe[i] = 1'b0; pin_out[i] = lat_q[i];   end
            endcase
         end
      end else begin : g_plain
         logic unused_ovr;
         always_comb begin
            unused_ovr = per_oe[i] ^ per_out[i];
            pin_oe[i]  = dir_q[i];
            pin_out[i] = lat_q[i];
         end
      end
   end

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux #(
   parameter int WIDTH     = 8,
   parameter int ADDR_W    = 2,
   parameter int DATA_ADDR = 0,
   parameter int DIR_ADDR  = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  pin_in,
   input  logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  rd_data,
   output logic [WIDTH-1:0]  per_in
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);

   always_comb begin
      per_in = pin_in;
      if (addr == A_DATA)     rd_data = pin_in;
      else if (addr == A_DIR) rd_data = dir_q;
      else                    rd_data = '0;
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int               WIDTH       = 8,
   parameter int               ADDR_W      = 2,
   parameter int               DATA_ADDR   = 0,
   parameter int               DIR_ADDR    = 1,
   parameter logic [WIDTH-1:0] PERIPH_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  per_oe,
   input  logic [WIDTH-1:0]  per_out,
   output logic [WIDTH-1:0]  per_in,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);

   localparam int NUM_ADDR = 2 ** ADDR_W;

   if (WIDTH < 1)                 begin : g_bad_w  $error("WIDTH must be at least 1"); end
   if (ADDR_W < 1)                begin : g_bad_aw $error("ADDR_W must be at least 1"); end
   if (DATA_ADDR == DIR_ADDR)     begin : g_bad_a  $error("register addresses collide"); end
   if (DATA_ADDR >= NUM_ADDR || DIR_ADDR >= NUM_ADDR)
                                  begin : g_bad_r  $error("register address out of range"); end

   logic [WIDTH-1:0] dir_q, lat_q;

   gpio_port_regs #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .dir_q(dir_q), .lat_q(lat_q)
   );

   gpio_port_drive #(
      .WIDTH(WIDTH), .PERIPH_MASK(PERIPH_MASK)
   ) u_drive (
      .dir_q(dir_q), .lat_q(lat_q), .per_oe(per_oe), .per_out(per_out),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   gpio_port_rdmux #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
   ) u_rdmux (
      .addr(addr), .pin_in(pin_in), .dir_q(dir_q), .rd_data(rd_data), .per_in(per_in)
   );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int               WIDTH       = 8,
   parameter int               ADDR_W      = 2,
   parameter int               DATA_ADDR   = 0,
   parameter int               DIR_ADDR    = 1,
   parameter logic [WIDTH-1:0] PERIPH_MASK = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [WIDTH-1:0]  wr_data,
   input logic [WIDTH-1:0]  rd_data,
   input logic [WIDTH-1:0]  per_oe,
   input logic [WIDTH-1:0]  per_out,
   input logic [WIDTH-1:0]  per_in,
   input logic [WIDTH-1:0]  pin_in,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  dir_q,
   input logic [WIDTH-1:0]  lat_q
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);

   assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIR) |=> dir_q == $past(wr_data));

   assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DATA) |=> lat_q == $past(wr_data));

   assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_DATA) |=> $stable(lat_q));

   assert_reset_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> dir_q == '0);

   assert_read_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_DATA) |-> rd_data == pin_in);

   assert_periph_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
      per_in == pin_in);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (PERIPH_MASK[i]) begin : g_ovr
         assert_periph_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
            per_oe[i] |-> (pin_oe[i] && pin_out[i] == per_out[i]));
         assert_out_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_q[i] && !per_oe[i]) |-> (pin_oe[i] && pin_out[i] == lat_q[i]));
         assert_input_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!dir_q[i] && !per_oe[i]) |-> !pin_oe[i]);
      end else begin : g_plain
         assert_masked_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] == dir_q[i]);
      end
   end

endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR),
   .PERIPH_MASK(PERIPH_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .per_oe(per_oe), .per_out(per_out), .per_in(per_in),
   .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .dir_q(dir_q), .lat_q(lat_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

   localparam int         W    = 8;
   localparam int         AW   = 2;
   localparam logic [7:0] MASK = 8'h3F;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic [W-1:0] per_oe = '0;
   logic [W-1:0] per_out = '0;
   logic [W-1:0] per_in;
   logic [W-1:0] pin_in;
   logic [W-1:0] pin_out;
   logic [W-1:0] pin_oe;
   logic [W-1:0] ext_val = 8'h3C;   // weak external level seen when undriven

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   // Resolved pad net: the port driver wins, otherwise the weak external level
   always_comb begin
      for (int i = 0; i < W; i++)
         pin_in[i] = pin_oe[i] ? pin_out[i] : ext_val[i];
   end

   gpio_port #(.WIDTH(W), .ADDR_W(AW), .DATA_ADDR(0), .DIR_ADDR(1), .PERIPH_MASK(MASK)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .per_oe(per_oe), .per_out(per_out), .per_in(per_in),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] r, lat, eff, eoe, eout, epin;
      // Reset state
      repeat (3) @(negedge clk);
      chk("R7 reset drive enables", pin_oe, 8'h00);
      rst_n = 1'b1;
      rd(2'd1, r); chk("R7 direction after reset", r, 8'h00);

      // Latch write in input mode: stored but not driven
      wr(2'd0, 8'hA5);
      chk("R3 input mode stays undriven", pin_oe, 8'h00);
      rd(2'd0, r); chk("R4 input read returns external level", r, ext_val);
      chk("R2 high impedance in input mode", pin_oe, 8'h00);
      wr(2'd1, 8'hFF);
      rd(2'd1, r); chk("R9 direction readback", r, 8'hFF);
      chk("R1 output drives latch", pin_out, 8'hA5);
      rd(2'd0, r); chk("R4 output read returns pin", r, 8'hA5);

      // Write timing
      @(negedge clk);
      addr = 2'd0; wr_data = 8'h3C; wr_en = 1'b1;
      #1 chk("R10 before write edge", pin_out, 8'hA5);
      @(posedge clk); #1;
      wr_en = 1'b0;
      chk("R10 after write edge", pin_out, 8'h3C);

      // Reset keeps the latch
      wr(2'd0, 8'h96);
      wr(2'd1, 8'h00);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(2'd1, r); chk("R7 direction cleared", r, 8'h00);
      wr(2'd1, 8'hFF);
      chk("R8 latch survives reset", pin_out, 8'h96);

      // Unmapped address
      wr(2'd2, 8'h5A);
      wr(2'd3, 8'h00);
      rd(2'd2, r); chk("R10 unmapped read zero", r, 8'h00);
      rd(2'd1, r); chk("R10 unmapped write leaves direction", r, 8'hFF);
      chk("R10 unmapped write leaves latch", pin_out, 8'h96);

      // Grid sweep over direction and override patterns
      for (int di = 0; di < 6; di++) begin
         for (int pi = 0; pi < 5; pi++) begin
            logic [W-1:0] dv, pv;
            case (di)
               0: dv = 8'h00; 1: dv = 8'hFF; 2: dv = 8'hAA;
               3: dv = 8'h55; 4: dv = 8'h0F; default: dv = 8'hF0;
            endcase
            case (pi)
               0: pv = 8'h00; 1: pv = 8'hFF; 2: pv = 8'h3C;
               3: pv = 8'hC3; default: pv = 8'h81;
            endcase
            lat = 8'(8'h5A ^ (di * 37 + pi * 11));
            wr(2'd0, lat);
            wr(2'd1, dv);
            @(negedge clk);
            per_oe  = pv;
            per_out = 8'(8'hC6 ^ (di * 13 + pi * 29));
            ext_val = 8'(8'h71 + di * 7 + pi * 3);
            #1;
            eff  = pv & MASK;
            eoe  = dv | eff;
            eout = (eff & per_out) | (~eff & lat);
            epin = (eoe & eout) | (~eoe & ext_val);
            chk("R1 R5 R11 drive enables", pin_oe, eoe);
            chk("R1 R5 driven values", pin_out & eoe, eout & eoe);
            chk("R2 undriven pins in input mode", pin_oe & ~dv & ~eff, 8'h00);
            rd(2'd0, r); chk("R4 pin readback", r, epin);
            chk("R6 peripheral input", per_in, epin);
            rd(2'd1, r); chk("R9 direction readback", r, dv);
            @(negedge clk);
            per_oe = '0;
            #1;
            chk("R3 latch held", pin_out & dv, lat & dv);
         end
      end

      finish_run();
   end

endmodule